// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This block brings up a charge pump and two groups of buck-regulator enables in a fixed order whenever supply-good is present and the external reset request is inactive. At that moment it samples a start-up selector (a 2-bit code from an outside three-level comparator) and a parallel-mode strap. From those two values it decides which regulator group comes up first, or whether any comes up at all. It then walks the sequence with parameterised tick counters and drives an active-low system reset output.

Channel A forms one group. Channels B and C always share a single enable, whether or not they run in parallel. Once the sequence has finished, a setup-register strobe can switch on further groups at once. No pump settle wait applies at that point. Losing supply-good, or holding the reset request longer than its deglitch window, turns everything off. When the cause clears, the whole sequence runs again from the start.

Top module: `pwrseq_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `cp_en`, `reg_a_en`, `reg_bc_en` and `rst_out_n` are all 0.
- R2: The selector and strap are captured once per start, on the cycle the sequence begins. Any later change is ignored until the next start.
- R3: Selector code 2'b10 or 2'b11 ("open") enables A first and the B/C group `GAP_TICKS` cycles later, whatever the strap value.
- R4: Selector code 2'b01 ("pull-down") with the strap high enables the B/C group first and A `GAP_TICKS` cycles later.
- R5: Selector code 2'b00 ("ground"), or code 2'b01 with the strap low, enables neither the pump nor any regulator. `rst_out_n` then rises `RSTREL_TICKS` cycles after the capture cycle.
- R6: `cp_en` rises on the capture cycle. The first group follows `SETTLE_TICKS` cycles later. `rst_out_n` rises together with the second group.
- R7: Once the sequence is complete, a `setup_strobe` raises `cp_en` and each requested group on the next cycle, with no settle wait. A strobe at any other time has no effect.
- R8: A reset request held for at least `DEGLITCH_TICKS` samples turns off all outputs and drives `rst_out_n` low. After the request is released, the full sequence runs again with a fresh capture.
- R9: A reset-request pulse shorter than `DEGLITCH_TICKS` samples changes no output.
- R10: Supply-good going low turns off all outputs, including `rst_out_n`, three cycles after the change at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_good | input | 1 | Supply above start threshold (asynchronous) |
| rst_req_in | input | 1 | External reset request, active high (asynchronous, deglitched) |
| sel_code | input | 2 | Start-up selector: 00 ground, 01 pull-down, 1x open |
| par_mode | input | 1 | Parallel-mode strap for the B/C pair |
| setup_strobe | input | 1 | One-cycle setup-register write strobe |
| setup_en_a | input | 1 | Setup request to enable channel A |
| setup_en_bc | input | 1 | Setup request to enable the B/C group |
| cp_en | output | 1 | Charge-pump enable |
| reg_a_en | output | 1 | Channel A regulator enable |
| reg_bc_en | output | 1 | Channels B and C regulator enable |
| rst_out_n | output | 1 | Active-low system reset output |

## Verification
The bench builds the block with a settle interval of 20 ticks, an inter-group gap of 7, a reset-release interval of 33 and a deglitch window of 4. Every branch of the sequence therefore completes within a few dozen cycles, and the exact edge of each output change can be predicted and compared. The small deglitch window puts both sides of the filter boundary within reach: a 3-cycle pulse must be dropped and a long request must take effect. The bench also covers selector changes in the middle of a sequence, setup strobes both inside and outside the finished state, and the skipped pump wait on the setup path.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        S_OFF    = 3'd0,
        S_SETTLE = 3'd1,
        S_GAP    = 3'd2,
        S_RUN    = 3'd3,
        S_HOLD   = 3'd4
    } seq_state_t;

    // Start plan decoded from the captured selector and strap
    typedef struct packed {
        logic none;      // no regulator at start
        logic bc_first;  // B/C group leads, A follows
    } plan_t;

    typedef struct packed {
        logic rstn;
        logic bc;
        logic a;
        logic cp;
    } seq_out_t;

    localparam logic [1:0] SEL_GND = 2'b00;
    localparam logic [1:0] SEL_PD  = 2'b01;

    function automatic plan_t decode_plan(input logic [1:0] code, input logic par);
        plan_t p;
        p.none     = (code == SEL_GND) || ((code == SEL_PD) && !par);
        p.bc_first = (code == SEL_PD) && par;
        return p;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pwrseq_deglitch.sv
module pwrseq_deglitch #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level
);
    localparam int DW = $clog2(HOLD + 1);
    localparam logic [DW-1:0] LAST = DW'(HOLD - 1);

    logic [DW-1:0] run_cnt;

    // level follows din only after HOLD consecutive differing samples
    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            level   <= 1'b0;
        end else if (din == level) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            run_cnt <= '0;
            level   <= din;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R9: a change of level is only possible at the end of a full window
    p_short_pulse_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> ($past(run_cnt) == LAST && $past(din) == level));

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int SETTLE_TICKS = 1000000,
    parameter int GAP_TICKS    = 160000,
    parameter int RSTREL_TICKS = 30000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sg_s,
    input  logic       rreq_f,
    input  logic [1:0] sel_s,
    input  logic       par_s,
    input  logic       setup_strobe,
    input  logic       setup_en_a,
    input  logic       setup_en_bc,
    output seq_out_t   outs
);
    localparam int MAXT  = max3(SETTLE_TICKS, GAP_TICKS, RSTREL_TICKS);
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(SETTLE_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_GAP    = CNT_W'(GAP_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_RSTREL = CNT_W'(RSTREL_TICKS - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] tick;
    plan_t            plan;
    plan_t            plan_now;
    logic             go_off;
    logic             tick_done;

    assign go_off    = !sg_s || rreq_f;
    assign tick_done = (tick == '0);
    assign plan_now  = decode_plan(sel_s, par_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_OFF;
            tick  <= '0;
            plan  <= '0;
            outs  <= '0;
        end else if (go_off) begin
            state <= S_OFF;
            tick  <= '0;
            outs  <= '0;
        end else begin
            unique case (state)
                S_OFF: begin
                    plan <= plan_now;
                    if (plan_now.none) begin
                        state <= S_HOLD;
                        tick  <= LD_RSTREL;
                    end else begin
                        state   <= S_SETTLE;
                        tick    <= LD_SETTLE;
                        outs.cp <= 1'b1;
                    end
                end
                S_SETTLE: begin
                    if (tick_done) begin
                        state <= S_GAP;
                        tick  <= LD_GAP;
                        if (plan.bc_first) outs.bc <= 1'b1;
                        else               outs.a  <= 1'b1;
                    end else begin
                        tick <= tick - 1'b1;
                    end
                end
                S_GAP: begin
                    if (tick_done) begin
                        state     <= S_RUN;
                        outs.a    <= 1'b1;
                        outs.bc   <= 1'b1;
                        outs.rstn <= 1'b1;
                    end else begin
                        tick <= tick - 1'b1;
                    end
                end
                S_HOLD: begin
                    if (tick_done) begin
                        state     <= S_RUN;
                        outs.rstn <= 1'b1;
                    end else begin
                        tick <= tick - 1'b1;
                    end
                end
                S_RUN: begin
                    if (setup_strobe && (setup_en_a || setup_en_bc)) begin
                        outs.cp <= 1'b1;
                        outs.a  <= outs.a  | setup_en_a;
                        outs.bc <= outs.bc | setup_en_bc;
                    end
                end
                default: state <= S_OFF;
            endcase
        end
    end

    // R2: the captured plan holds for the whole sequence
    p_plan_held_r2: assert property (@(posedge clk) disable iff (rst)
        (state != S_OFF && $past(state) != S_OFF) |-> $stable(plan));

    // R3: in A-first order the B/C group never rises ahead of A
    p_a_leads_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(outs.bc) && $past(state) == S_SETTLE && !plan.bc_first) |-> outs.a);

    // R6: no regulator enable without the pump
    p_pump_first_r6: assert property (@(posedge clk) disable iff (rst)
        (outs.a || outs.bc) |-> outs.cp);

    // R6: reset output only released at the end of a sequence
    p_rstn_release_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.rstn) |-> ($past(state) == S_GAP || $past(state) == S_HOLD));

    // R7: a strobe outside the finished state leaves the enables alone
    p_setup_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == S_HOLD && $past(setup_strobe)) |-> !outs.a && !outs.bc);

    // R10: supply loss or reset request clears every output
    p_all_off_r10: assert property (@(posedge clk) disable iff (rst)
        $past(go_off) |-> (outs == '0));

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int SETTLE_TICKS   = 1000000,
    parameter int GAP_TICKS      = 160000,
    parameter int RSTREL_TICKS   = 30000000,
    parameter int DEGLITCH_TICKS = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_good,
    input  logic       rst_req_in,
    input  logic [1:0] sel_code,
    input  logic       par_mode,
    input  logic       setup_strobe,
    input  logic       setup_en_a,
    input  logic       setup_en_bc,
    output logic       cp_en,
    output logic       reg_a_en,
    output logic       reg_bc_en,
    output logic       rst_out_n
);
    localparam int SYNC_W = 5;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] synced;
    logic              rreq_f;
    seq_out_t          outs;

    assign raw_in = {supply_good, rst_req_in, sel_code, par_mode};

    pwrseq_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (synced)
    );

    pwrseq_deglitch #(.HOLD(DEGLITCH_TICKS)) u_dg (
        .clk   (clk),
        .rst   (rst),
        .din   (synced[3]),
        .level (rreq_f)
    );

    pwrseq_ctrl #(
        .SETTLE_TICKS (SETTLE_TICKS),
        .GAP_TICKS    (GAP_TICKS),
        .RSTREL_TICKS (RSTREL_TICKS)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sg_s         (synced[4]),
        .rreq_f       (rreq_f),
        .sel_s        (synced[2:1]),
        .par_s        (synced[0]),
        .setup_strobe (setup_strobe),
        .setup_en_a   (setup_en_a),
        .setup_en_bc  (setup_en_bc),
        .outs         (outs)
    );

    assign cp_en     = outs.cp;
    assign reg_a_en  = outs.a;
    assign reg_bc_en = outs.bc;
    assign rst_out_n = outs.rstn;

endmodule

// File: tb/sim_pwrseq_top.sv
module sim_pwrseq_top;
    localparam int SETTLE = 20;
    localparam int GAP    = 7;
    localparam int RREL   = 33;
    localparam int DG     = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_good = 1'b0;
    logic       rst_req_in = 1'b0;
    logic [1:0] sel_code = 2'b10;
    logic       par_mode = 1'b0;
    logic       setup_strobe = 1'b0;
    logic       setup_en_a = 1'b0;
    logic       setup_en_bc = 1'b0;
    logic       cp_en, reg_a_en, reg_bc_en, rst_out_n;

    always #2 clk = ~clk;

    pwrseq_top #(
        .SETTLE_TICKS   (SETTLE),
        .GAP_TICKS      (GAP),
        .RSTREL_TICKS   (RREL),
        .DEGLITCH_TICKS (DG)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .supply_good  (supply_good),
        .rst_req_in   (rst_req_in),
        .sel_code     (sel_code),
        .par_mode     (par_mode),
        .setup_strobe (setup_strobe),
        .setup_en_a   (setup_en_a),
        .setup_en_bc  (setup_en_bc),
        .cp_en        (cp_en),
        .reg_a_en     (reg_a_en),
        .reg_bc_en    (reg_bc_en),
        .rst_out_n    (rst_out_n)
    );

    typedef struct {
        int         cyc;
        logic [3:0] vec;
        string      req;
    } exp_t;

    exp_t       sb[$];
    int         cyc = 0;
    int         n_run = 0;
    int         n_fail = 0;
    logic       mon_en = 1'b0;
    logic       done = 1'b0;
    logic [3:0] last_vec = 4'b0000;
    logic [3:0] outvec;

    assign outvec = {rst_out_n, reg_bc_en, reg_a_en, cp_en};

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int c, input logic [3:0] v, input string r);
        exp_t e;
        e.cyc = c;
        e.vec = v;
        e.req = r;
        sb.push_back(e);
    endtask

    task automatic chk(input string r, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s outputs actual=%b expected=%b at cycle %0d", r, act, exp, cyc);
        end
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: every output change must match the next scoreboard item
    always @(negedge clk) begin
        if (mon_en && !done && outvec !== last_vec) begin
            n_run++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected change actual=%b expected=%b at cycle %0d",
                         outvec, last_vec, cyc);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.vec !== outvec || e.cyc != cyc) begin
                    n_fail++;
                    $display("FAIL %s actual=%b@%0d expected=%b@%0d",
                             e.req, outvec, cyc, e.vec, e.cyc);
                end
            end
            last_vec = outvec;
        end
    end

    initial begin
        int n, c, m;
        repeat (3) @(negedge clk);
        chk("R1", outvec, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", outvec, 4'b0000);
        last_vec = 4'b0000;
        mon_en = 1'b1;

        // R3/R6: open code, strap low; selector changes mid-sequence (R2)
        repeat (3) @(negedge clk);
        n = cyc; supply_good = 1'b1; c = n + 3;
        push(c,              4'b0001, "R6");
        push(c + SETTLE,     4'b0011, "R3");
        push(c + SETTLE + GAP, 4'b1111, "R6");
        wait_until(c + 8);
        sel_code = 2'b00;
        wait_until(c + SETTLE + GAP + 3);
        chk("R2", outvec, 4'b1111);

        // R10: supply loss
        n = cyc; supply_good = 1'b0;
        push(n + 3, 4'b0000, "R10");
        wait_until(n + 6);

        // R4: pull-down with strap high, B/C first
        sel_code = 2'b01; par_mode = 1'b1;
        repeat (3) @(negedge clk);
        n = cyc; supply_good = 1'b1; c = n + 3;
        push(c,              4'b0001, "R6");
        push(c + SETTLE,     4'b0101, "R4");
        push(c + SETTLE + GAP, 4'b1111, "R4");
        wait_until(c + SETTLE + GAP + 3);

        // R9: reset pulse one sample short of the window
        n = cyc; rst_req_in = 1'b1;
        repeat (DG - 1) @(negedge clk);
        rst_req_in = 1'b0;
        wait_until(n + 15);
        chk("R9", outvec, 4'b1111);

        // R8: long reset request, then rerun with pull-down + strap low (R5)
        sel_code = 2'b01; par_mode = 1'b0;
        n = cyc; rst_req_in = 1'b1;
        push(n + 3 + DG, 4'b0000, "R8");
        repeat (10) @(negedge clk);
        m = cyc; rst_req_in = 1'b0; c = m + 3 + DG;
        push(c + RREL, 4'b1000, "R5");
        wait_until(c + 20);
        chk("R5", outvec, 4'b0000);
        wait_until(c + RREL + 3);

        // R7: setup strobes after completion, no settle wait
        n = cyc; setup_strobe = 1'b1; setup_en_a = 1'b1;
        push(n + 1, 4'b1011, "R7");
        @(negedge clk);
        setup_strobe = 1'b0; setup_en_a = 1'b0;
        @(negedge clk);
        n = cyc; setup_strobe = 1'b1; setup_en_bc = 1'b1;
        push(n + 1, 4'b1111, "R7");
        @(negedge clk);
        setup_strobe = 1'b0; setup_en_bc = 1'b0;
        repeat (3) @(negedge clk);

        // R7: strobe during the reset-release wait is ignored (ground, R5)
        n = cyc; supply_good = 1'b0;
        push(n + 3, 4'b0000, "R10");
        wait_until(n + 5);
        sel_code = 2'b00; par_mode = 1'b1;
        repeat (3) @(negedge clk);
        n = cyc; supply_good = 1'b1; c = n + 3;
        push(c + RREL, 4'b1000, "R5");
        wait_until(c + 5);
        setup_strobe = 1'b1; setup_en_a = 1'b1; setup_en_bc = 1'b1;
        @(negedge clk);
        setup_strobe = 1'b0; setup_en_a = 1'b0; setup_en_bc = 1'b0;
        wait_until(c + 10);
        chk("R7", outvec, 4'b0000);
        wait_until(c + RREL + 3);

        // R3: open code 2'b11 with strap high still leads with A
        n = cyc; supply_good = 1'b0;
        push(n + 3, 4'b0000, "R10");
        wait_until(n + 5);
        sel_code = 2'b11; par_mode = 1'b1;
        repeat (3) @(negedge clk);
        n = cyc; supply_good = 1'b1; c = n + 3;
        push(c,              4'b0001, "R6");
        push(c + SETTLE,     4'b0011, "R3");
        push(c + SETTLE + GAP, 4'b1111, "R3");
        wait_until(c + SETTLE + GAP + 3);

        n_run++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R6 scoreboard left actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule